// File: doc/BRIEF.md
# Interleaved page-mode DRAM controller

This block turns a processor's single and burst bus requests into page-mode cycles for a DRAM array made of two 32-bit leaves. Each leaf has its own multiplexed row/column address bus, one active-low row strobe per bank, one active-low column strobe per byte lane, and one active-low write enable. Every access opens a row and then switches the bus to the column. After the last word, the block holds all row strobes high for a precharge gap before it opens the next row.

The block has two modes. In interleaved mode, the lowest word-address bit picks the leaf and a burst alternates between the leaves, so it moves one word per clock. In non-interleaved mode only leaf A is used, and a burst needs two clocks per word because the column strobe must go high between words. A cycle-extend option adds one wait state before the first data word. The processor sees a `rdy` pulse for each word transferred. It ends a burst by raising `blast` during the last data cycle.

Top module: `pmdram_ctrl`

## Requirements
- R1: Out of reset and while idle, every row strobe, column strobe and write enable is high, `rdy` is low and both address buses are zero.
- R2: Address decode. In interleaved mode, `addr[0]` selects the leaf (0 = A, 1 = B), `addr[12:1]` is the column, `addr[24:13]` the row and `addr[26:25]` the bank. In non-interleaved mode, `addr[11:0]` is the column, `addr[23:12]` the row and `addr[25:24]` the bank, and `addr[26]` is ignored. Only the row strobe whose index equals the bank is driven low. In interleaved mode both leaves drive it.
- R3: In the clock after the request cycle, the row is on the address bus and the row strobe is low. In the next clock the column is on the bus. Column strobes go low only in data cycles, and only while the row strobe is held low.
- R4: A single access raises `rdy` in the third clock after the request cycle, or in the fourth when `cfg_ext` is set at the request.
- R5: All row strobes stay high for at least two clocks between accesses. For a request issued in the clock after `rdy`, the next row opens 3 clocks after that `rdy`. The two `rdy` pulses are 5 clocks apart, or 6 with cycle extend.
- R6: An interleaved burst starts on the addressed leaf and gives `rdy` on consecutive clocks, alternating leaves. The leaf column advances by one after each leaf-B word, and it wraps within the page.
- R7: A non-interleaved burst gives `rdy` every second clock, with the column rising by one per word. For the whole access, leaf B keeps its row strobes, column strobes and write enable high and its address bus at zero.
- R8: The data cycle in which `blast` is high is the last one. No further `rdy` follows until a new request.
- R9: In a data cycle, the active leaf drives `cas_n[i] = ~be[i]` and the other leaf's column strobes stay high.
- R10: For a write, the active leaf's write enable is low from the column cycle through each data cycle. For a read it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ilv | input | 1 | 1 = interleaved, 0 = leaf A only; sampled at request |
| cfg_ext | input | 1 | 1 = add one wait state before the first word; sampled at request |
| req | input | 1 | Access request, high for one clock |
| addr | input | 27 | Word address |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte-lane enables for the current word |
| blast | input | 1 | Current data cycle is the last of the access |
| rdy | output | 1 | One clock per word transferred |
| ma_a | output | 12 | Leaf A row/column address |
| ma_b | output | 12 | Leaf B row/column address |
| ras_a_n | output | 4 | Leaf A row strobes, one per bank, active low |
| ras_b_n | output | 4 | Leaf B row strobes, one per bank, active low |
| cas_a_n | output | 4 | Leaf A column strobes, one per byte lane, active low |
| cas_b_n | output | 4 | Leaf B column strobes, one per byte lane, active low |
| we_a_n | output | 1 | Leaf A write enable, active low |
| we_b_n | output | 1 | Leaf B write enable, active low |

## Verification
The embedded properties watch the timing relations that must hold on every clock:
- the two-clock row-strobe precharge gap;
- column strobes only under an open row;
- column strobes inside the byte enables;
- the one-clock gap after each word in non-interleaved mode;
- leaf alternation on back-to-back words.

Absolute latencies, address decode and column sequencing need the directed scenarios in the bench. So do the 5/6-clock spacing of back-to-back accesses, the quiet leaf B in non-interleaved mode, write-enable polarity and early burst termination. The bench computes the expected cycle numbers and addresses from the request it issues.

// File: rtl/pmdram_ctrl.sv
module pmdram_ctrl #(
  parameter int MA_W = 12,
  parameter int BK_W = 2,
  localparam int BANKS = 1 << BK_W,
  localparam int AW = 2 * MA_W + BK_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ilv,
  input  logic             cfg_ext,
  input  logic             req,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic [3:0]       be,
  input  logic             blast,
  output logic             rdy,
  output logic [MA_W-1:0]  ma_a,
  output logic [MA_W-1:0]  ma_b,
  output logic [BANKS-1:0] ras_a_n,
  output logic [BANKS-1:0] ras_b_n,
  output logic [3:0]       cas_a_n,
  output logic [3:0]       cas_b_n,
  output logic             we_a_n,
  output logic             we_b_n
);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_XW, S_DATA, S_CPRE, S_PRE1, S_PRE2
  } st_t;

  st_t st, st_nx;
  logic            ilv_q, ext_q, wr_q, leaf, pend;
  logic [BK_W-1:0] bank_q;
  logic [MA_W-1:0] row_q, lcol, col_a;
  logic [AW-2:0]   wa;
  logic [BANKS-1:0] bdec;
  logic            take, acc, colph, dat, ras_act, cas_act;

  assign wa   = cfg_ilv ? addr[AW-1:1] : addr[AW-2:0];
  assign take = req && (st == S_IDLE || st == S_PRE1 || (st == S_PRE2 && !pend));

  always_comb begin
    case (st)
      S_IDLE:  st_nx = req ? S_ROW : S_IDLE;
      S_ROW:   st_nx = S_COL;
      S_COL:   st_nx = ext_q ? S_XW : S_DATA;
      S_XW:    st_nx = S_DATA;
      S_DATA:  st_nx = blast ? S_PRE1 : (ilv_q ? S_DATA : S_CPRE);
      S_CPRE:  st_nx = S_DATA;
      S_PRE1:  st_nx = S_PRE2;
      S_PRE2:  st_nx = (pend || req) ? S_ROW : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ilv_q  <= 1'b0;
      ext_q  <= 1'b0;
      wr_q   <= 1'b0;
      leaf   <= 1'b0;
      pend   <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      lcol   <= '0;
    end else begin
      st   <= st_nx;
      pend <= (st == S_PRE1) && req;
      if (take) begin
        ilv_q  <= cfg_ilv;
        ext_q  <= cfg_ext;
        wr_q   <= wr;
        leaf   <= cfg_ilv & addr[0];
        lcol   <= wa[MA_W-1:0];
        row_q  <= wa[2*MA_W-1:MA_W];
        bank_q <= wa[AW-2:2*MA_W];
      end else if (st == S_DATA && !blast) begin
        leaf <= ilv_q & ~leaf;
        if (!ilv_q || leaf) lcol <= lcol + {{(MA_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assign acc   = (st == S_ROW) || (st == S_COL) || (st == S_XW) || (st == S_DATA) || (st == S_CPRE);
  assign colph = acc && (st != S_ROW);
  assign dat   = (st == S_DATA);
  assign bdec  = {{(BANKS-1){1'b0}}, 1'b1} << bank_q;
  assign col_a = (ilv_q && leaf) ? lcol + {{(MA_W-1){1'b0}}, 1'b1} : lcol;

  assign ras_a_n = acc ? ~bdec : '1;
  assign ras_b_n = (acc && ilv_q) ? ~bdec : '1;
  assign ma_a    = (st == S_ROW) ? row_q : (colph ? col_a : '0);
  assign ma_b    = !ilv_q ? '0 : ((st == S_ROW) ? row_q : (colph ? lcol : '0));
  assign cas_a_n = (dat && !leaf) ? ~be : 4'hF;
  assign cas_b_n = (dat && leaf) ? ~be : 4'hF;
  assign we_a_n  = ~(wr_q && colph && !leaf);
  assign we_b_n  = ~(wr_q && colph && leaf && ilv_q);
  assign rdy     = dat;

  assign ras_act = ~&ras_a_n;
  assign cas_act = ~&{cas_a_n, cas_b_n};

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_act) |=> !ras_act); // R5
  AST_CAS_UNDER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    cas_act |-> ($past(ras_act) && ras_act)); // R3
  AST_RDY_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> ($past(ras_act) && $past(ras_act, 2))); // R4
  AST_CAS_IN_BE: assert property (@(posedge clk) disable iff (!rst_n)
    (((~cas_a_n) | (~cas_b_n)) & ~be) == 4'h0); // R9
  AST_NILV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !ilv_q) |=> !rdy); // R7
  AST_ILV_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy)) |-> (leaf != $past(leaf))); // R6

endmodule

// File: tb/pmdram_ctrl_bench.sv
module pmdram_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_ilv, cfg_ext, req, wr, blast, rdy, we_a_n, we_b_n;
  logic [26:0] addr;
  logic [3:0] be, ras_a_n, ras_b_n, cas_a_n, cas_b_n;
  logic [11:0] ma_a, ma_b;

  pmdram_ctrl u_pmdram_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_ilv(cfg_ilv), .cfg_ext(cfg_ext), .req(req),
    .addr(addr), .wr(wr), .be(be), .blast(blast), .rdy(rdy),
    .ma_a(ma_a), .ma_b(ma_b), .ras_a_n(ras_a_n), .ras_b_n(ras_b_n),
    .cas_a_n(cas_a_n), .cas_b_n(cas_b_n), .we_a_n(we_a_n), .we_b_n(we_b_n));

  int vec = 0, fails = 0, cyc = 0, nw, req_cyc, row_cyc;
  bit done = 0, bquiet, cas_early;
  int rcyc[8];
  logic [3:0] rcas_a[8], rcas_b[8], rras_a, rras_b;
  logic [11:0] rma_a[8], rma_b[8], row_a, row_b, colma_a;
  logic rwe_a[8], rwe_b[8];

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic logic [26:0] mk(input logic ilv, input logic [1:0] bank,
                                     input logic [11:0] row, input logic [11:0] col, input logic lf);
    return ilv ? {bank, row, col, lf} : {1'b1, bank, row, col};
  endfunction

  task automatic access(input logic ilv, input logic ext, input logic w,
                        input logic [26:0] a, input logic [3:0] b, input int n);
    tick();
    cfg_ilv = ilv; cfg_ext = ext; wr = w; addr = a; be = b; blast = 1'b0; req = 1'b1;
    req_cyc = cyc; nw = 0; row_cyc = -1; bquiet = 1; cas_early = 0;
    for (int k = 0; k < 40 && nw < n; k++) begin
      tick();
      req = 1'b0;
      if (ras_b_n != 4'hF || cas_b_n != 4'hF || we_b_n !== 1'b1 || ma_b != 12'h0) bquiet = 0;
      if (row_cyc < 0 && ras_a_n != 4'hF) begin
        row_cyc = cyc; row_a = ma_a; row_b = ma_b; rras_a = ras_a_n; rras_b = ras_b_n;
      end
      if (row_cyc >= 0 && cyc == row_cyc + 1) colma_a = ma_a;
      if (!rdy && (cas_a_n != 4'hF || cas_b_n != 4'hF)) cas_early = 1;
      if (rdy) begin
        rcyc[nw] = cyc; rcas_a[nw] = cas_a_n; rcas_b[nw] = cas_b_n;
        rma_a[nw] = ma_a; rma_b[nw] = ma_b; rwe_a[nw] = we_a_n; rwe_b[nw] = we_b_n;
        nw++;
        blast = (nw == n);
      end
    end
    chk("R8", "words seen", nw, n);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic t_reset();
    chk("R1", "rdy", rdy, 0);
    chk("R1", "ras", {ras_a_n, ras_b_n}, 8'hFF);
    chk("R1", "cas", {cas_a_n, cas_b_n}, 8'hFF);
    chk("R1", "we", {we_a_n, we_b_n}, 2'b11);
    chk("R1", "ma", {ma_a, ma_b}, 24'h0);
  endtask

  task automatic t_simple(input logic ext);
    access(1, ext, 0, mk(1, 2'd2, 12'h5A3, 12'h0C4, 0), 4'hF, 1);
    chk("R4", "latency", rcyc[0] - req_cyc, 3 + ext);
    chk("R3", "row cycle", row_cyc - req_cyc, 1);
    chk("R2", "row on A", row_a, 12'h5A3);
    chk("R2", "row on B", row_b, 12'h5A3);
    chk("R2", "bank strobe A", rras_a, 4'b1011);
    chk("R2", "bank strobe B", rras_b, 4'b1011);
    chk("R3", "column after row", colma_a, 12'h0C4);
    chk("R3", "no early cas", cas_early, 0);
    chk("R2", "column at data", rma_a[0], 12'h0C4);
    chk("R9", "cas A", rcas_a[0], 4'h0);
    chk("R9", "cas B idle", rcas_b[0], 4'hF);
    chk("R10", "read we", {rwe_a[0], rwe_b[0]}, 2'b11);
    idle(4);
  endtask

  task automatic t_back2back(input logic ext);
    int first;
    access(1, ext, 0, mk(1, 2'd0, 12'h011, 12'h022, 0), 4'hF, 1);
    first = rcyc[0];
    access(1, ext, 0, mk(1, 2'd1, 12'h033, 12'h044, 1), 4'hF, 1);
    chk("R5", "rdy spacing", rcyc[0] - first, 5 + ext);
    chk("R5", "row reopen", row_cyc - first, 3);
    chk("R5", "second bank", rras_a, 4'b1101);
    idle(4);
  endtask

  task automatic t_ilv_burst();
    access(1, 0, 1, mk(1, 2'd3, 12'h777, 12'hFFE, 1), 4'hF, 4);
    chk("R4", "burst first", rcyc[0] - req_cyc, 3);
    for (int k = 1; k < 4; k++) chk("R6", "consecutive", rcyc[k] - rcyc[0], k);
    chk("R6", "w0 leaf B", {rcas_a[0], rcas_b[0]}, 8'hF0);
    chk("R6", "w1 leaf A", {rcas_a[1], rcas_b[1]}, 8'h0F);
    chk("R6", "w2 leaf B", {rcas_a[2], rcas_b[2]}, 8'hF0);
    chk("R6", "w3 leaf A", {rcas_a[3], rcas_b[3]}, 8'h0F);
    chk("R6", "w0 col", rma_b[0], 12'hFFE);
    chk("R6", "w1 col", rma_a[1], 12'hFFF);
    chk("R6", "w2 col", rma_b[2], 12'hFFF);
    chk("R6", "w3 col wrap", rma_a[3], 12'h000);
    chk("R10", "we w0", {rwe_a[0], rwe_b[0]}, 2'b10);
    chk("R10", "we w1", {rwe_a[1], rwe_b[1]}, 2'b01);
    idle(4);
  endtask

  task automatic t_nilv_burst();
    access(0, 1, 1, mk(0, 2'd1, 12'hABC, 12'h010, 0), 4'b0101, 3);
    chk("R4", "extended latency", rcyc[0] - req_cyc, 4);
    chk("R2", "row nilv", row_a, 12'hABC);
    chk("R2", "bank nilv", rras_a, 4'b1101);
    for (int k = 0; k < 3; k++) begin
      chk("R7", "every other clock", rcyc[k] - rcyc[0], 2 * k);
      chk("R7", "column step", rma_a[k], 12'h010 + k);
      chk("R9", "partial lanes", rcas_a[k], 4'b1010);
      chk("R10", "write we A", rwe_a[k], 0);
    end
    chk("R7", "leaf B quiet", bquiet, 1);
    idle(4);
  endtask

  task automatic t_blast_short();
    int extra = 0;
    access(1, 0, 0, mk(1, 2'd0, 12'h100, 12'h200, 0), 4'hF, 2);
    chk("R8", "two words back to back", rcyc[1] - rcyc[0], 1);
    for (int k = 0; k < 6; k++) begin
      tick();
      if (rdy) extra++;
    end
    chk("R8", "no rdy after blast", extra, 0);
    chk("R8", "rows closed", {ras_a_n, ras_b_n}, 8'hFF);
  endtask

  task automatic t_lane_b();
    access(1, 0, 0, mk(1, 2'd0, 12'h001, 12'h002, 1), 4'b1000, 1);
    chk("R9", "lane B only", rcas_b[0], 4'b0111);
    chk("R9", "leaf A off", rcas_a[0], 4'hF);
    chk("R10", "read we B", rwe_b[0], 1);
    chk("R2", "col on B", rma_b[0], 12'h002);
    idle(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_ilv = 0; cfg_ext = 0; req = 0; wr = 0; blast = 0; addr = '0; be = '0;
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_simple(0);
    t_simple(1);
    t_back2back(0);
    t_back2back(1);
    t_ilv_burst();
    t_nilv_burst();
    t_blast_short();
    t_lane_b();
    t_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule